// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This block is the shift stage of a small CPU datapath. Each cycle it may accept one operation on a 32-bit destination value. The operations are an arithmetic or logical right shift, a left shift, a fixed left shift by two, or a one-bit rotate through the carry flag. A variable shift takes its count from a second register value, from an 8-bit immediate, or uses a fixed count of one. The result, a write-enable and four updated condition flags (carry, zero, negative, overflow) are registered and appear one clock after the operation is presented.

A variable shift whose masked count is zero is a no-op. In that case the write-enable stays low, the result port echoes the operand and the flag outputs echo the incoming flags. The surrounding pipeline owns instruction fetch, decode of the machine encoding and program-counter stepping.

Top module: `shift_rotate_unit`

## Requirements
- R1: While reset is asserted (rstN low) and on the first cycle after it, result, wrEn and all four flag outputs are zero.
- R2: A variable-count shift uses only bits [4:0] of its count, whether the count comes from regCount (countSrc=0) or from immCount (countSrc=1). All higher count bits are ignored.
- R3: When the masked count of opSel 0, 1 or 2 is zero, wrEn stays low, result equals the operand, and carryOut/zeroOut/negOut/ovfOut equal carryIn/zeroIn/negIn/ovfIn.
- R4: Arithmetic right shift (opSel=0) fills vacated upper bits with operand bit 31. Logical right shift (opSel=1) fills them with zeros.
- R5: A right shift with a nonzero count loads carryOut with operand bit 0 as it was before the shift, for every count.
- R6: Left shift (opSel=2) with a nonzero count shifts in zeros and clears carryOut.
- R7: countSrc values 2 and 3 select a fixed count of one, so opSel 0, 1 and 2 always execute and write.
- R8: opSel=3 always writes operand shifted left by two with bits [1:0] zero, ignores the count inputs, and clears carryOut.
- R9: Rotate right (opSel=4) writes {carryIn, operand[31:1]} and sets carryOut to operand bit 0.
- R10: Rotate left (opSel=5) writes {operand[30:0], carryIn} and sets carryOut to operand bit 31.
- R11: On every write, zeroOut is set exactly when the 32-bit result is zero, negOut equals result bit 31, and ovfOut is cleared.
- R12: Outputs change one clock after the operation is presented. opSel values 6 and 7 never write.
- R13: With opValid low, wrEn stays low, result equals the operand and the flag outputs equal the incoming flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opSel | input | 3 | 0 arith right, 1 logical right, 2 left, 3 left by two, 4 rotate right, 5 rotate left |
| countSrc | input | 2 | 0 register count, 1 immediate count, 2 or 3 fixed count of one |
| operand | input | 32 | Destination register value before the operation |
| regCount | input | 32 | Count from a second register |
| immCount | input | 8 | Immediate count |
| carryIn | input | 1 | Current carry flag |
| zeroIn | input | 1 | Current zero flag |
| negIn | input | 1 | Current negative flag |
| ovfIn | input | 1 | Current overflow flag |
| result | output | 32 | Registered result |
| wrEn | output | 1 | Destination write strobe |
| carryOut | output | 1 | Updated carry flag |
| zeroOut | output | 1 | Updated zero flag |
| negOut | output | 1 | Updated negative flag |
| ovfOut | output | 1 | Updated overflow flag |

## Verification
Count masking and no-op suppression can fall in the same cycle. This happens when a raw count such as 32 or 64 has nonzero upper bits but masks to zero. The sweep drives every count from 0 to 63 through both the register and the immediate path, with varied upper bits. For those counts it judges that wrEn stays low and that the flags echo their inputs, where a shift by the raw count would have written. Carry capture and the shift itself also share a cycle, so each right shift is judged on both the shifted result and the pre-shift bit 0.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [2:0] {
    OP_SAR  = 3'd0,
    OP_SHR  = 3'd1,
    OP_SHL  = 3'd2,
    OP_SHL2 = 3'd3,
    OP_ROR  = 3'd4,
    OP_ROL  = 3'd5
  } shiftOpE;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_IMM = 2'd1,
    SRC_ONE = 2'd2
  } countSrcE;

  typedef struct packed {
    logic doWrite;
    logic goLeft;
    logic signFill;
    logic rotate;
  } shiftStrobeT;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 8,
  localparam int CNT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opSel,
  input  logic [1:0]       countSrc,
  input  logic [WIDTH-1:0] regCount,
  input  logic [IMM_W-1:0] immCount,
  output shiftStrobeT      strb,
  output logic [CNT_W-1:0] amount
);
  logic [CNT_W-1:0] rawCnt;
  logic             cntNonZero;

  always_comb begin
    unique case (countSrc)
      SRC_REG: rawCnt = regCount[CNT_W-1:0];
      SRC_IMM: rawCnt = immCount[CNT_W-1:0];
      default: rawCnt = CNT_W'(1);
    endcase
    cntNonZero = (rawCnt != '0);
  end

  always_comb begin
    strb   = '0;
    amount = rawCnt;
    unique case (opSel)
      OP_SAR: begin
        strb.signFill = 1'b1;
        strb.doWrite  = opValid && cntNonZero;
      end
      OP_SHR:  strb.doWrite = opValid && cntNonZero;
      OP_SHL: begin
        strb.goLeft  = 1'b1;
        strb.doWrite = opValid && cntNonZero;
      end
      OP_SHL2: begin
        strb.goLeft  = 1'b1;
        amount       = CNT_W'(2);
        strb.doWrite = opValid;
      end
      OP_ROR: begin
        strb.rotate  = 1'b1;
        strb.doWrite = opValid;
      end
      OP_ROL: begin
        strb.rotate  = 1'b1;
        strb.goLeft  = 1'b1;
        strb.doWrite = opValid;
      end
      default: strb = '0;
    endcase
  end

  // R2
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel <= 3'd2 && countSrc == 2'd0 && regCount[CNT_W-1:0] == '0) |-> !strb.doWrite);

  // R12
  write_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doWrite |-> opValid);

  // R7
  one_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && countSrc[1] && opSel <= 3'd2) |-> strb.doWrite);
endmodule

// File: rtl/shift_path.sv
module shift_path
  import shift_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  shiftStrobeT      strb,
  input  logic [CNT_W-1:0] amount,
  input  logic [WIDTH-1:0] operand,
  input  logic             carryIn,
  input  logic             zeroIn,
  input  logic             negIn,
  input  logic             ovfIn,
  output logic [WIDTH-1:0] resultQ,
  output logic             wrEnQ,
  output logic             carryQ,
  output logic             zeroQ,
  output logic             negQ,
  output logic             ovfQ
);
  logic [WIDTH-1:0] stage [CNT_W+1];
  logic [WIDTH-1:0] preRev, postRev, shifted, rotated, nextRes;
  logic             fillBit, nextCarry;

  // Left shifts reuse the right barrel by reversing bit order on both sides.
  for (genvar b = 0; b < WIDTH; b++) begin : g_rev
    assign preRev[b]  = strb.goLeft ? operand[WIDTH-1-b] : operand[b];
    assign shifted[b] = strb.goLeft ? postRev[WIDTH-1-b] : postRev[b];
  end

  assign fillBit  = strb.signFill & operand[WIDTH-1];
  assign stage[0] = preRev;

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    localparam int K = 1 << s;
    assign stage[s+1] = amount[s] ? {{K{fillBit}}, stage[s][WIDTH-1:K]} : stage[s];
  end
  assign postRev = stage[CNT_W];

  always_comb begin
    if (strb.goLeft) rotated = {operand[WIDTH-2:0], carryIn};
    else             rotated = {carryIn, operand[WIDTH-1:1]};
  end

  always_comb begin
    nextRes = strb.rotate ? rotated : shifted;
    if (strb.rotate)      nextCarry = strb.goLeft ? operand[WIDTH-1] : operand[0];
    else if (strb.goLeft) nextCarry = 1'b0;
    else                  nextCarry = operand[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      wrEnQ   <= 1'b0;
      carryQ  <= 1'b0;
      zeroQ   <= 1'b0;
      negQ    <= 1'b0;
      ovfQ    <= 1'b0;
    end else if (strb.doWrite) begin
      resultQ <= nextRes;
      wrEnQ   <= 1'b1;
      carryQ  <= nextCarry;
      zeroQ   <= (nextRes == '0);
      negQ    <= nextRes[WIDTH-1];
      ovfQ    <= 1'b0;
    end else begin
      resultQ <= operand;
      wrEnQ   <= 1'b0;
      carryQ  <= carryIn;
      zeroQ   <= zeroIn;
      negQ    <= negIn;
      ovfQ    <= ovfIn;
    end
  end

  logic seen;
  always_ff @(posedge clk) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  // R11
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEnQ |-> (zeroQ == (resultQ == '0)) && (negQ == resultQ[WIDTH-1]));

  // R11
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEnQ |-> !ovfQ);

  // R3
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen && !wrEnQ) |-> (carryQ == $past(carryIn)) && (ovfQ == $past(ovfIn))
                         && (resultQ == $past(operand)));

  // R9
  ror_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(strb.doWrite && strb.rotate && !strb.goLeft))
      |-> (resultQ[WIDTH-1] == $past(carryIn)) && (carryQ == $past(operand[0])));

  // R5
  right_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(strb.doWrite && !strb.rotate && !strb.goLeft))
      |-> carryQ == $past(operand[0]));
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shift_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [2:0]  opSel,
  input  logic [1:0]  countSrc,
  input  logic [31:0] operand,
  input  logic [31:0] regCount,
  input  logic [7:0]  immCount,
  input  logic        carryIn,
  input  logic        zeroIn,
  input  logic        negIn,
  input  logic        ovfIn,
  output logic [31:0] result,
  output logic        wrEn,
  output logic        carryOut,
  output logic        zeroOut,
  output logic        negOut,
  output logic        ovfOut
);
  localparam int WIDTH = 32;
  localparam int IMM_W = 8;
  localparam int CNT_W = $clog2(WIDTH);

  shiftStrobeT      strb;
  logic [CNT_W-1:0] amount;

  shift_ctrl #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .countSrc(countSrc), .regCount(regCount), .immCount(immCount),
    .strb(strb), .amount(amount)
  );

  shift_path #(.WIDTH(WIDTH)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .amount(amount),
    .operand(operand), .carryIn(carryIn), .zeroIn(zeroIn),
    .negIn(negIn), .ovfIn(ovfIn),
    .resultQ(result), .wrEnQ(wrEn), .carryQ(carryOut),
    .zeroQ(zeroOut), .negQ(negOut), .ovfQ(ovfOut)
  );
endmodule

// File: tb/tb_shift_rotate_unit.sv
module tb_shift_rotate_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic [1:0]  countSrc = '0;
  logic [31:0] operand = '0;
  logic [31:0] regCount = '0;
  logic [7:0]  immCount = '0;
  logic        carryIn = 1'b0, zeroIn = 1'b0, negIn = 1'b0, ovfIn = 1'b0;
  logic [31:0] result;
  logic        wrEn, carryOut, zeroOut, negOut, ovfOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  shift_rotate_unit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .countSrc(countSrc), .operand(operand), .regCount(regCount),
    .immCount(immCount), .carryIn(carryIn), .zeroIn(zeroIn),
    .negIn(negIn), .ovfIn(ovfIn), .result(result), .wrEn(wrEn),
    .carryOut(carryOut), .zeroOut(zeroOut), .negOut(negOut), .ovfOut(ovfOut)
  );

  // {we, result, c, z, n, v}
  logic [36:0] exp;
  string tagRes, tagFlg;

  task automatic check(input string tag, input logic [36:0] act, input logic [36:0] want);
    checks++;
    if (act !== want) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, want);
    end
  endtask

  task automatic model(input logic v, input logic [2:0] op, input logic [1:0] src,
                       input logic [31:0] a, input logic [31:0] rc, input logic [7:0] ic,
                       input logic ci, input logic zi, input logic ni, input logic vi);
    int eff;
    logic we;
    logic [31:0] r;
    logic c;
    eff = (src == 2'd0) ? int'(rc[4:0]) : (src == 2'd1) ? int'(ic[4:0]) : 1;
    we = 1'b0; r = a; c = ci;
    tagRes = "R12"; tagFlg = "R12";
    case (op)
      3'd0: begin we = (eff != 0); r = 32'($signed(a) >>> eff); c = a[0]; tagRes = "R4"; tagFlg = "R5"; end
      3'd1: begin we = (eff != 0); r = a >> eff; c = a[0]; tagRes = "R4"; tagFlg = "R5"; end
      3'd2: begin we = (eff != 0); r = a << eff; c = 1'b0; tagRes = "R6"; tagFlg = "R6"; end
      3'd3: begin we = 1'b1; r = {a[29:0], 2'b00}; c = 1'b0; tagRes = "R8"; tagFlg = "R8"; end
      3'd4: begin we = 1'b1; r = {ci, a[31:1]}; c = a[0]; tagRes = "R9"; tagFlg = "R9"; end
      3'd5: begin we = 1'b1; r = {a[30:0], ci}; c = a[31]; tagRes = "R10"; tagFlg = "R10"; end
      default: we = 1'b0;
    endcase
    if (op <= 3'd2 && src[1]) begin tagRes = "R7"; end
    if (op <= 3'd2 && !src[1] && eff == 0) begin tagRes = "R3"; tagFlg = "R3"; end
    else if (op <= 3'd2 && !src[1] && (src == 2'd0 ? rc[31:5] != 0 : ic[7:5] != 0) && !we)
      tagRes = "R2";
    we = we && v;
    if (!v) begin tagRes = "R13"; tagFlg = "R13"; end
    if (we) exp = {1'b1, r, c, (r == 32'd0), r[31], 1'b0};
    else    exp = {1'b0, a, ci, zi, ni, vi};
  endtask

  task automatic apply(input logic v, input logic [2:0] op, input logic [1:0] src,
                       input logic [31:0] a, input logic [31:0] rc, input logic [7:0] ic,
                       input logic [3:0] fl);
    @(negedge clk);
    opValid = v; opSel = op; countSrc = src; operand = a; regCount = rc; immCount = ic;
    {carryIn, zeroIn, negIn, ovfIn} = fl;
    model(v, op, src, a, rc, ic, fl[3], fl[2], fl[1], fl[0]);
    @(negedge clk);
    // R12: registered one clock after presentation
    check(tagRes, {wrEn, result}, exp[36:4]);
    check(wrEn ? "R11" : tagFlg, {carryOut, zeroOut, negOut, ovfOut}, exp[3:0]);
    if (exp[36]) check(tagFlg, {31'd0, carryOut}, {31'd0, exp[3]});
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  logic [31:0] pats [4];

  initial begin
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hA5C3_0F96;
    pats[3] = 32'h0000_0000;
    opSel = 3'd4; operand = 32'hFFFF_FFFF; carryIn = 1'b1; opValid = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset holds all outputs at zero even with a write request
    check("R1", {wrEn, result, carryOut, zeroOut, negOut, ovfOut}, 37'd0);
    @(negedge clk);
    rstN = 1'b1; opValid = 1'b0;
    // R1: first cycle after reset still shows reset values
    check("R1", {wrEn, result, carryOut, zeroOut, negOut, ovfOut}, 37'd0);
    // Sweep R2..R13: op x source x count 0..63 x operand x flag input
    for (int op = 0; op < 8; op++)
      for (int src = 0; src < 4; src++)
        for (int cnt = 0; cnt < 64; cnt++)
          for (int p = 0; p < 4; p++)
            for (int f = 0; f < 2; f++)
              apply(1'b1, 3'(op), 2'(src), pats[p] ^ 32'(cnt * 32'h0101_0101),
                    {cnt[0] ? 26'h2AA_AAAA : 26'h0, 6'(cnt)}, {2'(cnt), 6'(cnt)},
                    f ? 4'b1011 : 4'b0100);
    // R13: opValid low blocks every operation
    for (int op = 0; op < 6; op++)
      apply(1'b0, 3'(op), 2'd2, 32'hDEAD_BEEF, 32'd1, 8'd1, 4'b1101);
    // R11: zero result sets zero flag, negative flag tracks bit 31
    apply(1'b1, 3'd1, 2'd1, 32'h0000_0001, 32'd0, 8'd1, 4'b0001);
    apply(1'b1, 3'd2, 2'd0, 32'h0000_0001, 32'd31, 8'd0, 4'b0001);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end
endmodule